// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This block holds the modem-control byte of one UART channel and drives everything that byte steers. A simple register bus writes and reads it at offset 0 and reads the modem status byte at offset 1. The control byte drives the active-low request-to-send and data-terminal-ready pins and the general-purpose OP pin. It also drives the output enable of the interrupt line, a divide-by-4 clock prescale select, an address-map select for the transmission-control and trigger-level registers, and an enable for the FIFO-ready status register.

Writes to the three top control bits are accepted only while an unlock input, which comes from the enhanced-feature register elsewhere in the channel, is high. Writes to the five low bits are always accepted.

When internal loopback is on, the serial transmit stream is returned to the receive path, and the external receive pin is ignored. The external transmit pin rests at mark, and the modem pins rest at their inactive level. The four low control bits stand in for the four modem inputs in the status byte. The status byte's low nibble holds change flags for the four modem lines, and a status read clears them.

Top module: `mdm_ctl_unit`

## Requirements
- R1: Synchronous reset clears the control byte to 0x00 and the change flags to 0000, so that rts_n, dtr_n and op_n are 1 and irq_oe, prescale_div4, alt_map_sel and fifo_rdy_en are 0.
- R2: A write at offset 0 with feat_unlock=1 loads all eight control bits from the next clock edge, and a read at offset 0 returns them.
- R3: A write at offset 0 with feat_unlock=0 leaves control bits 7:5 unchanged and loads bits 4:0.
- R4: prescale_div4 follows control bit 7, alt_map_sel follows bit 6 and fifo_rdy_en follows bit 2.
- R5: Outside loopback (bit 4 = 0), rts_n is the inverse of bit 1 and dtr_n is the inverse of bit 0. op_n is the inverse of bit 3. irq_oe equals bit 3 in every mode.
- R6: Outside loopback with auto_rts_en=1, rts_n is the inverse of auto_rts_lvl, and control bit 1 has no effect on the pin.
- R7: Outside loopback, status bits 7,6,5,4 equal the inverses of dcd_n, ri_n, dsr_n and cts_n, in that order, in the same cycle.
- R8: In loopback, status bit 4 is control bit 1, status bit 5 is bit 0, status bit 6 is bit 2 and status bit 7 is bit 3.
- R9: In loopback, rx_ser_out equals tx_ser_in and rx_ser_pin is ignored. Outside loopback, rx_ser_out equals rx_ser_pin and tx_ser_pin equals tx_ser_in.
- R10: In loopback, rts_n, dtr_n, op_n and tx_ser_pin are held at 1, even when auto-RTS is enabled.
- R11: Status bits 0, 1 and 3 are set one cycle after any change of status bits 4, 5 and 7 respectively. Status bit 2 is set only when status bit 6 falls from 1 to 0.
- R12: A read at offset 1 clears all four change flags at the next edge. A change that is detected at that same edge still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect: clears flags at offset 1) |
| reg_addr | input | 1 | 0 = control byte, 1 = status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| feat_unlock | input | 1 | Allows writes to control bits 7:5 |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| auto_rts_en | input | 1 | Hardware flow control owns RTS |
| auto_rts_lvl | input | 1 | Hardware flow control request, 1 = assert |
| tx_ser_in | input | 1 | Serial stream from the transmitter |
| rx_ser_pin | input | 1 | External receive pin |
| tx_ser_pin | output | 1 | External transmit pin |
| rx_ser_out | output | 1 | Serial stream to the receiver |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| op_n | output | 1 | General-purpose output, active low |
| irq_oe | output | 1 | Output enable of the interrupt line |
| prescale_div4 | output | 1 | 1 = divide the input clock by 4 |
| alt_map_sel | output | 1 | Selects the transmission-control and trigger-level registers |
| fifo_rdy_en | output | 1 | Enables the FIFO-ready status register |

## Verification
Almost every output is a combinational image of the control byte. A wrong bit in that byte therefore shows on a pin, or in the offset-0 read data, in the same cycle that follows the faulty write edge. A corrupted previous-line register or change flag shows up one cycle after the line event, in the low nibble of an offset-1 read: a flag is set that should not be, a falling edge of the ring line is missed, or a flag fails to clear after a read. A wrong loopback route shows at once on the serial and modem pins, and in the upper status nibble.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int BYTE_W = 8;
    localparam int LINE_N = 4;
    localparam int RI_POS = 2;

    localparam logic ADDR_CTL  = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Control bits whose writes need the unlock input.
    localparam logic [BYTE_W-1:0] LOCKED_BITS = 8'hE0;

    typedef struct packed {
        logic div4;      // bit 7
        logic alt_map;   // bit 6
        logic xon_any;   // bit 5
        logic loop_en;   // bit 4
        logic irq_op;    // bit 3
        logic fifo_rdy;  // bit 2
        logic rts;       // bit 1
        logic dtr;       // bit 0
    } ctl_t;

    // Active-high modem line view, MSB = status bit 7.
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    function automatic line_t loop_lines(input ctl_t c);
        line_t l;
        l.dcd = c.irq_op;
        l.ri  = c.fifo_rdy;
        l.dsr = c.dtr;
        l.cts = c.rts;
        return l;
    endfunction

    function automatic ctl_t merge_write(input ctl_t cur, input ctl_t wd,
                                         input logic unlock);
        logic [BYTE_W-1:0] keep;
        keep = unlock ? '0 : LOCKED_BITS;
        return ctl_t'((wd & ~keep) | (cur & keep));
    endfunction

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  ctl_t wdata,
    input  logic unlock,
    output ctl_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr)
            q <= merge_write(q, wdata, unlock);
    end
endmodule

// File: rtl/mdm_route.sv
module mdm_route
    import mdm_pkg::*;
(
    input  ctl_t  ctl,
    input  line_t ext_lines,
    input  logic  auto_en,
    input  logic  auto_lvl,
    input  logic  tx_in,
    input  logic  rx_pin,
    output line_t lines,
    output logic  tx_pin,
    output logic  rx_out,
    output logic  rts_n,
    output logic  dtr_n,
    output logic  op_n,
    output logic  irq_oe
);
    logic rts_req;

    always_comb begin
        rts_req = auto_en ? auto_lvl : ctl.rts;
        irq_oe  = ctl.irq_op;
        if (ctl.loop_en) begin
            lines  = loop_lines(ctl);
            tx_pin = 1'b1;
            rx_out = tx_in;
            rts_n  = 1'b1;
            dtr_n  = 1'b1;
            op_n   = 1'b1;
        end else begin
            lines  = ext_lines;
            tx_pin = tx_in;
            rx_out = rx_pin;
            rts_n  = ~rts_req;
            dtr_n  = ~ctl.dtr;
            op_n   = ~ctl.irq_op;
        end
    end
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg #(
    parameter int LINE_N = 4,
    parameter int RI_POS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_N-1:0] lines,
    input  logic              clr,
    output logic [LINE_N-1:0] delta
);
    logic [LINE_N-1:0] prev_q;
    logic [LINE_N-1:0] event_w;

    for (genvar i = 0; i < LINE_N; i++) begin : g_evt
        if (i == RI_POS) begin : g_trail
            assign event_w[i] = prev_q[i] & ~lines[i];
        end else begin : g_any
            assign event_w[i] = prev_q[i] ^ lines[i];
        end
    end

    always_ff @(posedge clk) begin
        prev_q <= lines;
        if (rst)
            delta <= '0;
        else
            delta <= (clr ? '0 : delta) | event_w;
    end
endmodule

// File: rtl/mdm_ctl_unit.sv
module mdm_ctl_unit
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              feat_unlock,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    input  logic              auto_rts_en,
    input  logic              auto_rts_lvl,
    input  logic              tx_ser_in,
    input  logic              rx_ser_pin,
    output logic              tx_ser_pin,
    output logic              rx_ser_out,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              op_n,
    output logic              irq_oe,
    output logic              prescale_div4,
    output logic              alt_map_sel,
    output logic              fifo_rdy_en
);
    ctl_t              ctl_q;
    line_t             ext_lines;
    line_t             lines_w;
    logic [LINE_N-1:0] delta_q;
    logic              ctl_wr;
    logic              stat_rd;

    assign ctl_wr  = reg_wr && (reg_addr == ADDR_CTL);
    assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

    assign ext_lines = '{dcd: ~dcd_n, ri: ~ri_n, dsr: ~dsr_n, cts: ~cts_n};

    mdm_ctl_reg u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr     (ctl_wr),
        .wdata  (ctl_t'(reg_wdata)),
        .unlock (feat_unlock),
        .q      (ctl_q)
    );

    mdm_route u_route (
        .ctl       (ctl_q),
        .ext_lines (ext_lines),
        .auto_en   (auto_rts_en),
        .auto_lvl  (auto_rts_lvl),
        .tx_in     (tx_ser_in),
        .rx_pin    (rx_ser_pin),
        .lines     (lines_w),
        .tx_pin    (tx_ser_pin),
        .rx_out    (rx_ser_out),
        .rts_n     (rts_n),
        .dtr_n     (dtr_n),
        .op_n      (op_n),
        .irq_oe    (irq_oe)
    );

    mdm_stat_reg #(.LINE_N(LINE_N), .RI_POS(RI_POS)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .lines (lines_w),
        .clr   (stat_rd),
        .delta (delta_q)
    );

    assign prescale_div4 = ctl_q.div4;
    assign alt_map_sel   = ctl_q.alt_map;
    assign fifo_rdy_en   = ctl_q.fifo_rdy;

    assign reg_rdata = (reg_addr == ADDR_STAT) ? {lines_w, delta_q} : ctl_q;
endmodule

// File: rtl/mdm_ctl_chk.sv
module mdm_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic       feat_unlock,
    input logic       auto_rts_en,
    input logic       auto_rts_lvl,
    input logic       tx_ser_in,
    input logic       tx_ser_pin,
    input logic       rx_ser_out,
    input logic       rts_n,
    input logic       dtr_n,
    input logic       op_n,
    input logic [7:0] ctl_q,
    input logic [3:0] lines_w,
    input logic [3:0] delta_q
);
    // R1
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (ctl_q == 8'h00 && delta_q == 4'h0));

    // R2
    p_open_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && feat_unlock) |=> ctl_q == $past(reg_wdata));

    // R3
    p_locked_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && !feat_unlock)
        |=> (ctl_q[7:5] == $past(ctl_q[7:5]) && ctl_q[4:0] == $past(reg_wdata[4:0])));

    // R6
    p_auto_rts_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q[4] && auto_rts_en) |-> rts_n == !auto_rts_lvl);

    // R8
    p_loop_map_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_q[4] |-> lines_w == {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]});

    // R9
    p_loop_serial_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_q[4] |-> rx_ser_out == tx_ser_in);

    // R10
    p_loop_idle_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_q[4] |-> (rts_n && dtr_n && op_n && tx_ser_pin));

    // R11
    p_ri_trailing_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_q[2]) |-> !$past(lines_w[2]));

    // R12
    p_read_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr && $stable(lines_w)) |=> delta_q == 4'h0);
endmodule

bind mdm_ctl_unit mdm_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .feat_unlock  (feat_unlock),
    .auto_rts_en  (auto_rts_en),
    .auto_rts_lvl (auto_rts_lvl),
    .tx_ser_in    (tx_ser_in),
    .tx_ser_pin   (tx_ser_pin),
    .rx_ser_out   (rx_ser_out),
    .rts_n        (rts_n),
    .dtr_n        (dtr_n),
    .op_n         (op_n),
    .ctl_q        (ctl_q),
    .lines_w      (lines_w),
    .delta_q      (delta_q)
);

// File: tb/mdm_ctl_unit_tb.sv
module mdm_ctl_unit_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, reg_wr, reg_rd, reg_addr, feat_unlock;
    logic [7:0] reg_wdata, reg_rdata;
    logic       cts_n, dsr_n, ri_n, dcd_n, auto_rts_en, auto_rts_lvl;
    logic       tx_ser_in, rx_ser_pin, tx_ser_pin, rx_ser_out;
    logic       rts_n, dtr_n, op_n, irq_oe, prescale_div4, alt_map_sel, fifo_rdy_en;

    mdm_ctl_unit u_dut (.*);

    typedef struct {
        string       req;
        logic [16:0] exp;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Requirement model
    logic [7:0] m_ctl;
    logic [3:0] m_delta, m_prev;

    wire [16:0] obs = {rts_n, dtr_n, op_n, irq_oe, prescale_div4, alt_map_sel,
                       fifo_rdy_en, tx_ser_pin, rx_ser_out, reg_rdata};

    function automatic logic [3:0] m_lines();
        if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
        return ~{dcd_n, ri_n, dsr_n, cts_n};
    endfunction

    function automatic logic [16:0] m_obs();
        logic lp;
        logic [7:0] rd;
        lp = m_ctl[4];
        rd = reg_addr ? {m_lines(), m_delta} : m_ctl;
        return {lp ? 1'b1 : ~(auto_rts_en ? auto_rts_lvl : m_ctl[1]),
                lp ? 1'b1 : ~m_ctl[0],
                lp ? 1'b1 : ~m_ctl[3],
                m_ctl[3], m_ctl[7], m_ctl[6], m_ctl[2],
                lp ? 1'b1 : tx_ser_in,
                lp ? tx_ser_in : rx_ser_pin,
                rd};
    endfunction

    task automatic step();
        logic [3:0] h, ev, nd;
        logic [7:0] nc;
        h = m_lines();
        ev = h ^ m_prev;
        ev[2] = m_prev[2] & ~h[2];
        nc = m_ctl;
        if (rst) begin
            nc = 8'h00;
            nd = 4'h0;
        end else begin
            if (reg_wr && !reg_addr)
                nc = feat_unlock ? reg_wdata : {m_ctl[7:5], reg_wdata[4:0]};
            nd = ((reg_rd && reg_addr) ? 4'h0 : m_delta) | ev;
        end
        @(posedge clk);
        #1;
        m_ctl = nc;
        m_delta = nd;
        m_prev = h;
    endtask

    task automatic chk(input string r);
        item_t it;
        it.req = r;
        it.exp = m_obs();
        q.push_back(it);
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [7:0] v, input logic unl);
        reg_addr = 1'b0;
        reg_wdata = v;
        feat_unlock = unl;
        reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_run++;
            if (obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.req, obs, it.exp);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        feat_unlock = 0; cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1;
        auto_rts_en = 0; auto_rts_lvl = 0; tx_ser_in = 1; rx_ser_pin = 1;
        m_ctl = 8'h00; m_delta = 4'h0; m_prev = 4'h0;
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        chk("R1 reset state, control read");
        sample();
        reg_addr = 1'b1; #1;
        chk("R1 reset flags clear");
        sample();

        // Unlocked write of all bits except loopback
        wr_ctl(8'hE5, 1'b1);
        chk("R2 unlocked write / R4 / R5 pins");
        sample();

        // Locked write keeps bits 7:5
        wr_ctl(8'h0A, 1'b0);
        chk("R3 locked write keeps 7:5 (expect EA)");
        sample();
        wr_ctl(8'h1A & 8'h0F, 1'b0);
        chk("R3 low bits update under lock");
        sample();

        wr_ctl(8'h00, 1'b1);
        chk("R2 unlocked clear of upper bits / R4 outputs low");
        sample();

        // Auto RTS
        wr_ctl(8'h02, 1'b1);
        chk("R5 rts from control bit 1");
        sample();
        auto_rts_en = 1'b1; auto_rts_lvl = 1'b0; #1;
        chk("R6 auto-RTS deasserts pin despite bit 1");
        sample();
        auto_rts_lvl = 1'b1; #1;
        chk("R6 auto-RTS asserts pin");
        sample();
        auto_rts_en = 1'b0; auto_rts_lvl = 1'b0;

        // Modem inputs and change flags
        reg_addr = 1'b1;
        cts_n = 1'b0;
        step();
        chk("R7 cts line / R11 cts flag set");
        sample();
        dcd_n = 1'b0;
        step();
        chk("R7 dcd line / R11 dcd flag set");
        sample();
        reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
        chk("R12 read clears flags");
        sample();
        ri_n = 1'b0;
        step();
        chk("R11 ri rising does not set flag");
        sample();
        ri_n = 1'b1;
        step();
        chk("R11 ri falling sets flag");
        sample();
        reg_rd = 1'b1;
        dsr_n = 1'b0;
        step();
        reg_rd = 1'b0;
        chk("R12 event on read edge keeps dsr flag");
        sample();
        reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
        chk("R12 second read clears");
        sample();

        // Serial path, normal mode
        reg_addr = 1'b0;
        tx_ser_in = 1'b0; rx_ser_pin = 1'b1; #1;
        chk("R9 normal serial path a");
        sample();
        tx_ser_in = 1'b1; rx_ser_pin = 1'b0; #1;
        chk("R9 normal serial path b");
        sample();

        // Loopback mapping, one bit at a time
        begin
            logic [7:0] pat [4];
            pat[0] = 8'h12; pat[1] = 8'h11; pat[2] = 8'h14; pat[3] = 8'h18;
            for (int k = 0; k < 4; k++) begin
                wr_ctl(pat[k], 1'b1);
                reg_addr = 1'b1; #1;
                chk("R8 loopback status mapping");
                sample();
                step();
                chk("R11 flags after loopback change");
                sample();
            end
        end
        wr_ctl(8'h1F, 1'b1);
        auto_rts_en = 1'b1; auto_rts_lvl = 1'b1; #1;
        chk("R10 loopback pins idle with auto-RTS");
        sample();
        tx_ser_in = 1'b0; rx_ser_pin = 1'b1; #1;
        chk("R9 loopback tx to rx a");
        sample();
        tx_ser_in = 1'b1; rx_ser_pin = 1'b0; #1;
        chk("R9 loopback ignores rx pin b");
        sample();
        reg_addr = 1'b1; cts_n = 1'b1; dcd_n = 1'b1; #1;
        chk("R8 external lines ignored in loopback");
        sample();

        // Leave loopback
        auto_rts_en = 1'b0;
        wr_ctl(8'h0B, 1'b1);
        chk("R5 normal pins after loopback exit");
        sample();
        reg_addr = 1'b1; #1;
        chk("R7 external lines after loopback exit");
        sample();

        sample();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule